// File: doc/BRIEF.md
# Operand Address Resolution Unit

This block turns an instruction's addressing request into a concrete operand location for an 8-bit microcontroller core. The instruction decoder supplies an addressing mode, the opcode byte and any appended address byte. The core's architectural state supplies the two bank-select bits, the contents of working registers 0 and 1, the stack pointer, the accumulator, the data pointer and the program counter. The block answers with a target space (internal RAM, special-function space, program memory, or none) and an address. For stack operations it also returns the updated stack pointer.

The same numeric byte can land in different places depending on the mode. A direct address splits on its top bit: low values reach RAM and high values reach special-function space. A pointer taken from a working register always reaches the full 256-byte RAM, including its upper half, and never reaches special-function space. Immediate operands produce no address. Instead they raise a flag so the datapath uses the appended byte as data. Requests whose opcode does not fit the selected mode, and stack moves that would wrap the pointer, are flagged as illegal and resolve to no space.

A request is sampled when the valid strobe is high. The result appears on the registered outputs one clock later. The data outputs hold until the next strobe, and the valid output pulses for that one cycle.

Top module: `opnd_addr_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `res_valid`, `res_imm` and `res_illegal` are 0, `res_space` is 0 (none), and `res_addr` and `res_sp_next` are 0 until the first strobe.
- R2: Mode 0 (register) resolves to space 1 (internal RAM) at address {bank_sel, opcode[2:0]}. The request is illegal when opcode[3] is 0.
- R3: Mode 1 (direct) uses `addr_byte` as the address. Values 0x00 to 0x7F go to space 1 (RAM) and values 0x80 to 0xFF go to space 2 (special-function).
- R4: Mode 2 (register-indirect) uses `r0_val` when opcode[0] is 0 and `r1_val` when it is 1, and always resolves to space 1, even for pointers of 0x80 or more. The request is illegal unless opcode[3:1] is 3'b011.
- R5: Mode 3 (push) resolves to space 1 at sp+1 and returns sp+1 on `res_sp_next`. The request is illegal when sp is 0xFF.
- R6: Mode 4 (pop) resolves to space 1 at sp and returns sp-1 on `res_sp_next`. The request is illegal when sp is 0x00.
- R7: Mode 5 resolves to space 3 (program memory) at (dptr+acc) mod 65536, and mode 6 to space 3 at (pc+acc) mod 65536. Neither raises a flag on wrap.
- R8: Mode 7 (immediate) sets `res_imm`, resolves to space 0 with address 0, and does not set `res_illegal`.
- R9: An illegal request sets `res_illegal`, resolves to space 0 with address 0, clears `res_imm`, and returns the unchanged sp on `res_sp_next`. Modes other than push and pop also return the unchanged sp.
- R10: The result of a request sampled at a clock edge appears right after that edge. `res_valid` is 1 for exactly that one cycle. Without a strobe, all data outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 3 | Addressing mode code (0 to 7) |
| opcode | input | 8 | Opcode byte |
| addr_byte | input | 8 | Appended address byte |
| bank_sel | input | 2 | Register bank select bits |
| r0_val | input | 8 | Working register 0 of the current bank |
| r1_val | input | 8 | Working register 1 of the current bank |
| sp_val | input | 8 | Stack pointer |
| acc_val | input | 8 | Accumulator |
| dptr_val | input | 16 | Data pointer |
| pc_val | input | 16 | Program counter |
| res_valid | output | 1 | One-cycle result pulse |
| res_space | output | 2 | 0 none, 1 RAM, 2 special-function, 3 program memory |
| res_addr | output | 16 | Resolved address |
| res_sp_next | output | 8 | Stack pointer after the operation |
| res_imm | output | 1 | Operand is the appended byte itself |
| res_illegal | output | 1 | Request was rejected |

## Verification
Two functions can meet in one cycle: a stack move must update the pointer, while the wrap guard must suppress that update. A push at pointer 0xFF or a pop at 0x00 therefore has to report illegal, no space, and the unchanged pointer, all in the same result. The bench also sends requests on consecutive cycles, so that a new result replaces the held one with no idle cycle in between. A behavioural model checks every output on every clock against values derived from the requirements.

// File: rtl/oau_pkg.sv
package oau_pkg;
  parameter int OAU_DW  = 8;
  parameter int OAU_CAW = 16;

  typedef enum logic [2:0] {
    MD_REG       = 3'd0,
    MD_DIRECT    = 3'd1,
    MD_INDIRECT  = 3'd2,
    MD_PUSH      = 3'd3,
    MD_POP       = 3'd4,
    MD_CODE_DPTR = 3'd5,
    MD_CODE_PC   = 3'd6,
    MD_IMM       = 3'd7
  } oau_mode_e;

  typedef enum logic [1:0] {
    SPC_NONE = 2'd0,
    SPC_IRAM = 2'd1,
    SPC_SFR  = 2'd2,
    SPC_CODE = 2'd3
  } oau_space_e;

  // Working register location inside the banked RAM window
  function automatic logic [OAU_DW-1:0] bank_reg_addr(input logic [1:0] bank,
                                                      input logic [2:0] idx);
    return {{(OAU_DW-5){1'b0}}, bank, idx};
  endfunction

  // Top bit of a direct address chooses between RAM and register space
  function automatic oau_space_e direct_space(input logic [OAU_DW-1:0] a);
    return a[OAU_DW-1] ? SPC_SFR : SPC_IRAM;
  endfunction

  // Indirect opcodes carry 3'b011 in bits [3:1]
  function automatic logic indirect_form_ok(input logic [OAU_DW-1:0] op);
    return op[3:1] == 3'b011;
  endfunction

  // Base plus unsigned index, truncated to the code address width
  function automatic logic [OAU_CAW-1:0] code_sum(input logic [OAU_CAW-1:0] base,
                                                  input logic [OAU_DW-1:0]  idx);
    return base + {{(OAU_CAW-OAU_DW){1'b0}}, idx};
  endfunction
endpackage

// File: rtl/oau_ram_path.sv
module oau_ram_path
  import oau_pkg::*;
#(
  parameter int DW = OAU_DW
) (
  input  oau_mode_e        mode,
  input  logic [DW-1:0]    opcode,
  input  logic [DW-1:0]    addr_byte,
  input  logic [1:0]       bank,
  input  logic [DW-1:0]    r0,
  input  logic [DW-1:0]    r1,
  output logic             hit,
  output oau_space_e       space,
  output logic [DW-1:0]    addr,
  output logic             illegal
);
  always_comb begin
    hit     = 1'b0;
    space   = SPC_NONE;
    addr    = '0;
    illegal = 1'b0;
    unique case (mode)
      MD_REG: begin
        hit     = 1'b1;
        space   = SPC_IRAM;
        addr    = bank_reg_addr(bank, opcode[2:0]);
        illegal = ~opcode[3];
      end
      MD_DIRECT: begin
        hit   = 1'b1;
        space = direct_space(addr_byte);
        addr  = addr_byte;
      end
      MD_INDIRECT: begin
        hit     = 1'b1;
        space   = SPC_IRAM;
        addr    = opcode[0] ? r1 : r0;
        illegal = ~indirect_form_ok(opcode);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/oau_stack_path.sv
module oau_stack_path
  import oau_pkg::*;
#(
  parameter int DW = OAU_DW
) (
  input  oau_mode_e     mode,
  input  logic [DW-1:0] sp,
  output logic          hit,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] sp_next,
  output logic          illegal
);
  localparam logic [DW-1:0] SP_TOP = '1;
  localparam logic [DW-1:0] SP_BOT = '0;
  localparam logic [DW-1:0] ONE    = DW'(1);

  always_comb begin
    hit     = 1'b0;
    addr    = '0;
    sp_next = sp;
    illegal = 1'b0;
    if (mode == MD_PUSH) begin
      hit     = 1'b1;
      addr    = sp + ONE;
      sp_next = sp + ONE;
      illegal = (sp == SP_TOP);
    end else if (mode == MD_POP) begin
      hit     = 1'b1;
      addr    = sp;
      sp_next = sp - ONE;
      illegal = (sp == SP_BOT);
    end
  end
endmodule

// File: rtl/oau_code_path.sv
module oau_code_path
  import oau_pkg::*;
#(
  parameter int DW  = OAU_DW,
  parameter int CAW = OAU_CAW
) (
  input  oau_mode_e      mode,
  input  logic [DW-1:0]  acc,
  input  logic [CAW-1:0] dptr,
  input  logic [CAW-1:0] pc,
  output logic           hit,
  output logic [CAW-1:0] addr
);
  logic [CAW-1:0] base;

  always_comb begin
    hit  = (mode == MD_CODE_DPTR) || (mode == MD_CODE_PC);
    base = (mode == MD_CODE_PC) ? pc : dptr;
    addr = hit ? code_sum(base, acc) : '0;
  end
endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import oau_pkg::*;
#(
  parameter int DW  = OAU_DW,
  parameter int CAW = OAU_CAW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [2:0]     req_mode,
  input  logic [DW-1:0]  opcode,
  input  logic [DW-1:0]  addr_byte,
  input  logic [1:0]     bank_sel,
  input  logic [DW-1:0]  r0_val,
  input  logic [DW-1:0]  r1_val,
  input  logic [DW-1:0]  sp_val,
  input  logic [DW-1:0]  acc_val,
  input  logic [CAW-1:0] dptr_val,
  input  logic [CAW-1:0] pc_val,
  output logic           res_valid,
  output logic [1:0]     res_space,
  output logic [CAW-1:0] res_addr,
  output logic [DW-1:0]  res_sp_next,
  output logic           res_imm,
  output logic           res_illegal
);
  localparam int PADW = CAW - DW;

  oau_mode_e mode;
  assign mode = oau_mode_e'(req_mode);

  // Event wires, one per resolution path
  logic           ram_hit, stk_hit, code_hit, imm_hit;
  oau_space_e     ram_space;
  logic [DW-1:0]  ram_addr, stk_addr, stk_sp_next;
  logic           ram_ill, stk_ill;
  logic [CAW-1:0] code_addr;

  oau_ram_path #(.DW(DW)) u_ram (
    .mode(mode), .opcode(opcode), .addr_byte(addr_byte), .bank(bank_sel),
    .r0(r0_val), .r1(r1_val),
    .hit(ram_hit), .space(ram_space), .addr(ram_addr), .illegal(ram_ill)
  );

  oau_stack_path #(.DW(DW)) u_stk (
    .mode(mode), .sp(sp_val),
    .hit(stk_hit), .addr(stk_addr), .sp_next(stk_sp_next), .illegal(stk_ill)
  );

  oau_code_path #(.DW(DW), .CAW(CAW)) u_code (
    .mode(mode), .acc(acc_val), .dptr(dptr_val), .pc(pc_val),
    .hit(code_hit), .addr(code_addr)
  );

  assign imm_hit = (mode == MD_IMM);

  oau_space_e     nxt_space;
  logic [CAW-1:0] nxt_addr;
  logic [DW-1:0]  nxt_sp;
  logic           nxt_imm, nxt_ill;

  always_comb begin
    nxt_space = SPC_NONE;
    nxt_addr  = '0;
    nxt_sp    = sp_val;
    nxt_imm   = 1'b0;
    nxt_ill   = 1'b0;
    if (ram_hit) begin
      nxt_space = ram_space;
      nxt_addr  = {{PADW{1'b0}}, ram_addr};
      nxt_ill   = ram_ill;
    end else if (stk_hit) begin
      nxt_space = SPC_IRAM;
      nxt_addr  = {{PADW{1'b0}}, stk_addr};
      nxt_sp    = stk_sp_next;
      nxt_ill   = stk_ill;
    end else if (code_hit) begin
      nxt_space = SPC_CODE;
      nxt_addr  = code_addr;
    end else if (imm_hit) begin
      nxt_imm = 1'b1;
    end
    if (nxt_ill) begin
      nxt_space = SPC_NONE;
      nxt_addr  = '0;
      nxt_sp    = sp_val;
      nxt_imm   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_space   <= 2'(SPC_NONE);
      res_addr    <= '0;
      res_sp_next <= '0;
      res_imm     <= 1'b0;
      res_illegal <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_space   <= 2'(nxt_space);
        res_addr    <= nxt_addr;
        res_sp_next <= nxt_sp;
        res_imm     <= nxt_imm;
        res_illegal <= nxt_ill;
      end
    end
  end
endmodule

// File: rtl/oau_checker.sv
module oau_checker #(
  parameter int DW  = 8,
  parameter int CAW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic [2:0]     req_mode,
  input logic [DW-1:0]  addr_byte,
  input logic [DW-1:0]  sp_val,
  input logic           res_valid,
  input logic [1:0]     res_space,
  input logic [CAW-1:0] res_addr,
  input logic [DW-1:0]  res_sp_next,
  input logic           res_imm,
  input logic           res_illegal,
  input logic           ram_hit,
  input logic           stk_hit,
  input logic           code_hit
);
  localparam logic [DW-1:0] SP_TOP = '1;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!res_valid && !res_illegal && !res_imm));

  assert_direct_low_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 3'd1 && !addr_byte[DW-1]) |=> res_space == 2'd1);

  assert_indirect_never_sfr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 3'd2) |=> res_space != 2'd2);

  assert_push_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 3'd3 && sp_val != SP_TOP) |=>
      res_sp_next == DW'($past(sp_val) + DW'(1)));

  assert_imm_no_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_imm) |-> (res_space == 2'd0 && res_addr == '0 && !res_illegal));

  assert_illegal_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_illegal) |-> (res_space == 2'd0 && res_addr == '0));

  assert_single_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_hit, stk_hit, code_hit}));

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(res_addr) && $stable(res_space) && $stable(res_sp_next)));
endmodule

bind opnd_addr_unit oau_checker #(.DW(DW), .CAW(CAW)) u_oau_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .addr_byte(addr_byte), .sp_val(sp_val),
  .res_valid(res_valid), .res_space(res_space), .res_addr(res_addr),
  .res_sp_next(res_sp_next), .res_imm(res_imm), .res_illegal(res_illegal),
  .ram_hit(ram_hit), .stk_hit(stk_hit), .code_hit(code_hit)
);

// File: tb/test_opnd_addr_unit.sv
module test_opnd_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_mode;
  logic [7:0]  opcode, addr_byte, r0_val, r1_val, sp_val, acc_val;
  logic [1:0]  bank_sel;
  logic [15:0] dptr_val, pc_val;
  logic        res_valid, res_imm, res_illegal;
  logic [1:0]  res_space;
  logic [15:0] res_addr;
  logic [7:0]  res_sp_next;

  int checks = 0;
  int errors = 0;

  // Reference model state
  int    e_valid, e_space, e_addr, e_sp, e_imm, e_ill;
  string e_tag;

  always #5 clk = ~clk;

  opnd_addr_unit i_opnd_addr_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .opcode(opcode), .addr_byte(addr_byte), .bank_sel(bank_sel),
    .r0_val(r0_val), .r1_val(r1_val), .sp_val(sp_val), .acc_val(acc_val),
    .dptr_val(dptr_val), .pc_val(pc_val),
    .res_valid(res_valid), .res_space(res_space), .res_addr(res_addr),
    .res_sp_next(res_sp_next), .res_imm(res_imm), .res_illegal(res_illegal)
  );

  // Behavioural model: integer arithmetic straight from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid = 0; e_space = 0; e_addr = 0; e_sp = 0; e_imm = 0; e_ill = 0;
      e_tag = "R1";
    end else if (!req_valid) begin
      e_valid = 0;
      e_tag = "R10";
    end else begin
      int sp_i, space, addr, spn, imm, ill;
      sp_i = sp_val; space = 0; addr = 0; spn = sp_i; imm = 0; ill = 0;
      case (req_mode)
        3'd0: begin space = 1; addr = bank_sel * 8 + opcode % 8;
                    ill = ((opcode / 8) % 2 == 0); e_tag = "R2"; end
        3'd1: begin space = (addr_byte >= 128) ? 2 : 1; addr = addr_byte; e_tag = "R3"; end
        3'd2: begin space = 1; addr = (opcode % 2 == 1) ? r1_val : r0_val;
                    ill = ((opcode / 2) % 8 != 3); e_tag = "R4"; end
        3'd3: begin space = 1; addr = sp_i + 1; spn = sp_i + 1; ill = (sp_i == 255); e_tag = "R5"; end
        3'd4: begin space = 1; addr = sp_i; spn = sp_i - 1; ill = (sp_i == 0); e_tag = "R6"; end
        3'd5: begin space = 3; addr = (dptr_val + acc_val) % 65536; e_tag = "R7"; end
        3'd6: begin space = 3; addr = (pc_val + acc_val) % 65536; e_tag = "R7"; end
        default: begin imm = 1; e_tag = "R8"; end
      endcase
      if (ill) begin
        space = 0; addr = 0; spn = sp_i; imm = 0; e_tag = "R9";
      end
      e_valid = 1; e_space = space; e_addr = addr; e_sp = spn; e_imm = imm; e_ill = ill;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare every clock, a few ns after the edge
  always @(posedge clk) begin
    #3;
    check(e_tag, "res_valid",   int'(res_valid),   e_valid);
    check(e_tag, "res_space",   int'(res_space),   e_space);
    check(e_tag, "res_addr",    int'(res_addr),    e_addr);
    check(e_tag, "res_sp_next", int'(res_sp_next), e_sp);
    check(e_tag, "res_imm",     int'(res_imm),     e_imm);
    check(e_tag, "res_illegal", int'(res_illegal), e_ill);
  end

  task automatic req(input logic [2:0] m, input logic [7:0] op, input logic [7:0] ab,
                     input logic [1:0] bk, input logic [7:0] p0, input logic [7:0] p1,
                     input logic [7:0] sp, input logic [7:0] ac,
                     input logic [15:0] dp, input logic [15:0] pc);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; opcode = op; addr_byte = ab; bank_sel = bk;
    r0_val = p0; r1_val = p1; sp_val = sp; acc_val = ac; dptr_val = dp; pc_val = pc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      addr_byte = addr_byte ^ 8'h5A;
      sp_val = sp_val + 8'd3;
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = '0; opcode = '0; addr_byte = '0;
    bank_sel = '0; r0_val = '0; r1_val = '0; sp_val = '0; acc_val = '0;
    dptr_val = '0; pc_val = '0;
    repeat (3) @(negedge clk);   // R1: reset state compared each clock
    rst_n = 1'b1;
    idle(2);                     // R1: stays clear after release
    // R2: register mode across banks, and a legal/illegal pair
    req(3'd0, 8'hEF, 8'h00, 2'd2, 8'h00, 8'h00, 8'h07, 8'h00, 16'h0, 16'h0);
    req(3'd0, 8'h0D, 8'h00, 2'd3, 8'h00, 8'h00, 8'h07, 8'h00, 16'h0, 16'h0);
    req(3'd0, 8'h05, 8'h00, 2'd1, 8'h00, 8'h00, 8'h07, 8'h00, 16'h0, 16'h0);
    idle(2);                     // R10: hold with moving inputs
    // R3: direct split around the boundary
    req(3'd1, 8'hE5, 8'h7F, 2'd0, 8'h00, 8'h00, 8'h07, 8'h00, 16'h0, 16'h0);
    req(3'd1, 8'hE5, 8'h80, 2'd0, 8'h00, 8'h00, 8'h07, 8'h00, 16'h0, 16'h0);
    req(3'd1, 8'hE5, 8'hF0, 2'd0, 8'h00, 8'h00, 8'h07, 8'h00, 16'h0, 16'h0);
    // R4: indirect through R0 / R1, upper pointer stays in RAM, bad form
    req(3'd2, 8'hE6, 8'h80, 2'd0, 8'h90, 8'h22, 8'h07, 8'h00, 16'h0, 16'h0);
    req(3'd2, 8'hE7, 8'h80, 2'd0, 8'h90, 8'hA5, 8'h07, 8'h00, 16'h0, 16'h0);
    req(3'd2, 8'hE4, 8'h80, 2'd0, 8'h90, 8'hA5, 8'h07, 8'h00, 16'h0, 16'h0);
    idle(1);
    // R5 / R6: stack moves and the wrap guards (R9)
    req(3'd3, 8'hC0, 8'h00, 2'd0, 8'h00, 8'h00, 8'h07, 8'h00, 16'h0, 16'h0);
    req(3'd3, 8'hC0, 8'h00, 2'd0, 8'h00, 8'h00, 8'hFE, 8'h00, 16'h0, 16'h0);
    req(3'd3, 8'hC0, 8'h00, 2'd0, 8'h00, 8'h00, 8'hFF, 8'h00, 16'h0, 16'h0);
    req(3'd4, 8'hD0, 8'h00, 2'd0, 8'h00, 8'h00, 8'h30, 8'h00, 16'h0, 16'h0);
    req(3'd4, 8'hD0, 8'h00, 2'd0, 8'h00, 8'h00, 8'h01, 8'h00, 16'h0, 16'h0);
    req(3'd4, 8'hD0, 8'h00, 2'd0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0, 16'h0);
    idle(2);
    // R7: code lookups including wrap
    req(3'd5, 8'h93, 8'h00, 2'd0, 8'h00, 8'h00, 8'h07, 8'h10, 16'h1234, 16'h0400);
    req(3'd5, 8'h93, 8'h00, 2'd0, 8'h00, 8'h00, 8'h07, 8'h02, 16'hFFFF, 16'h0400);
    req(3'd6, 8'h83, 8'h00, 2'd0, 8'h00, 8'h00, 8'h07, 8'hFF, 16'h1234, 16'hFF80);
    // R8: immediate
    req(3'd7, 8'h74, 8'h55, 2'd0, 8'h00, 8'h00, 8'h07, 8'h00, 16'h0, 16'h0);
    idle(3);
    // Mid-run reset (R1)
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    @(negedge clk); rst_n = 1'b1;
    req(3'd2, 8'hE6, 8'h00, 2'd3, 8'hFF, 8'h00, 8'h40, 8'h00, 16'h0, 16'h0);
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule